// File: doc/BRIEF.md
# Sync Event Interrupt Controller

This block gathers seven single-cycle event pulses from a display sync monitor (changes in horizontal or vertical sync presence, polarity and frequency, plus a per-frame vertical sync event) into sticky pending flags. Each flag can be masked by its own enable bit. Whenever at least one enabled flag is pending, an active-low interrupt line to a small microcontroller is held low.

Software reaches the block through an 8-bit register port with two write targets. The flag-clear target clears a flag when a 0 is written to that flag's bit. A 1 written to a bit leaves that flag as it is. The enable target is write-only. The pending flags are always visible on the read bus.

Flags never clear on their own. The interrupt service routine must therefore acknowledge each event by writing zeros to the matching flag bits.

Top module: `sync_evt_irq_ctrl`

## Requirements
- R1: When reset is asserted, every flag and every enable bit is cleared. After reset, `rd_data` reads 0x00 and `irq_n` is 1.
- R2: A 1 on `evt_i[k]` in a cycle sets flag k at the next clock edge, and flag k then reads as 1 on `rd_data[k]`. The bit map is fixed: bit 6 = horizontal presence change, bit 5 = vertical presence change, bit 4 = horizontal polarity change, bit 3 = vertical polarity change, bit 2 = horizontal frequency change or overflow, bit 1 = vertical frequency change or overflow, bit 0 = vertical sync event.
- R3: A set flag stays set over any number of cycles until software clears it.
- R4: A write with `wr_sel` = 0 (the flag-clear target) clears every flag whose bit in `wr_data` is 0. Flags whose bit in `wr_data` is 1 are left unchanged.
- R5: If an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R6: `irq_n` is a registered output. It goes low one clock after a flag and its enable bit are both 1. It returns high one clock after no enabled flag remains.
- R7: A write with `wr_sel` = 1 loads `wr_data[6:0]` into the enable register. A pending flag whose enable bit is 0 does not pull `irq_n` low. Setting that enable bit later does pull `irq_n` low.
- R8: `rd_data[7]` always reads 0. `wr_data[7]` has no effect on flags or enables.
- R9: Flags are set by their events whatever the state of the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 7 | Single-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = flag clear, 1 = enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Pending flags, bit 7 reads 0 |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is a clearing write and a new event landing on the same flag in the same clock cycle. The bench sets both up in one drive step, with the event bit and a zero data bit at the same position. It then reads the flag back directly. The bench also checks, cycle by cycle, the one-clock lag of `irq_n` behind the flag and enable registers. To do this it samples right after the flag update, when `irq_n` must still be high, and again one clock later.

// File: rtl/sei_pkg.sv
package sei_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned BUS_W   = 8;

  typedef enum logic {
    TGT_CLEAR  = 1'b0,
    TGT_ENABLE = 1'b1
  } wr_target_e;
endpackage

// File: rtl/sei_flag_cell.sv
module sei_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sei_flag_bank.sv
module sei_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] flags_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cell
      logic clr_bit;
      assign clr_bit = clr_wr_i & ~clr_data_i[g];
      sei_flag_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_i[g]),
        .clr_i  (clr_bit),
        .flag_o (flags_o[g])
      );
    end
  endgenerate
endmodule

// File: rtl/sei_enable_reg.sv
module sei_enable_reg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)         en_o <= '0;
    else if (load_i) en_o <= data_i;
  end
endmodule

// File: rtl/sei_irq_out.sv
module sei_irq_out #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_n_o
);
  logic pending;
  assign pending = |(flags_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~pending;
  end
endmodule

// File: rtl/sync_evt_irq_ctrl.sv
module sync_evt_irq_ctrl
  import sei_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] enables;
  logic             clr_wr;
  logic             en_wr;

  assign clr_wr = wr_en & (wr_target_e'(wr_sel) == TGT_CLEAR);
  assign en_wr  = wr_en & (wr_target_e'(wr_sel) == TGT_ENABLE);

  sei_flag_bank #(.N(N_SRC)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .clr_wr_i   (clr_wr),
    .clr_data_i (wr_data[N_SRC-1:0]),
    .flags_o    (flags)
  );

  sei_enable_reg #(.N(N_SRC)) u_en (
    .clk    (clk),
    .rst    (rst),
    .load_i (en_wr),
    .data_i (wr_data[N_SRC-1:0]),
    .en_o   (enables)
  );

  sei_irq_out #(.N(N_SRC)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags),
    .en_i    (enables),
    .irq_n_o (irq_n)
  );

  assign rd_data = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/sei_checker.sv
module sei_checker #(
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  evt_i,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_n
);
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_bit
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        evt_i[g] |=> rd_data[g]); // R2
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[g] && !(wr_en && !wr_sel && !wr_data[g])) |=> rd_data[g]); // R3
      AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !wr_data[g] && !evt_i[g]) |=> !rd_data[g]); // R4
      AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt_i[g] && wr_en && !wr_sel && !wr_data[g]) |=> rd_data[g]); // R5
    end
  endgenerate

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rd_data[N_SRC-1:0] == '0) |=> irq_n); // R6
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_data[DATA_W-1]); // R8
endmodule

bind sync_evt_irq_ctrl sei_checker #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_sei_chk (
  .clk     (clk),
  .rst     (rst),
  .evt_i   (evt_i),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq_n   (irq_n)
);

// File: tb/sync_evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module sync_evt_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] evt_i = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_evt_irq_ctrl uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; returns just after the edge that samples it.
  task automatic step(input logic [6:0] e, input logic we, input logic sel, input logic [7:0] d);
    @(negedge clk);
    evt_i = e; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    evt_i = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R1 flags", rd_data, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_set_each();
    logic [7:0] acc = 8'h00;
    for (int k = 0; k < 7; k++) begin
      step(7'(1 << k), 1'b0, 1'b0, 8'h00);
      acc[k] = 1'b1;
      check("R2 set bit", rd_data, acc);
    end
    idle();
    check("R9 set without enable, irq idle", {7'd0, irq_n}, 8'h01);
    step('0, 1'b1, 1'b0, 8'h00);
    check("R4 clear all", rd_data, 8'h00);
  endtask

  task automatic t_sticky();
    step(7'h08, 1'b0, 1'b0, 8'h00);
    repeat (5) idle();
    check("R3 sticky", rd_data, 8'h08);
    step('0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_clear_partial();
    step(7'h7F, 1'b0, 1'b0, 8'h00);
    step('0, 1'b1, 1'b0, 8'hF0);
    check("R4 zero bits clear", rd_data, 8'h70);
    step('0, 1'b1, 1'b0, 8'h7F);
    check("R8 bit7 zero ignored, ones keep", rd_data, 8'h70);
    step('0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_collide();
    step(7'h04, 1'b1, 1'b0, 8'h00);
    check("R5 event beats clear", rd_data, 8'h04);
  endtask

  task automatic t_irq_mask();
    // flag bit2 pending, enables still 0
    idle();
    check("R7 masked flag no irq", {7'd0, irq_n}, 8'h01);
    step('0, 1'b1, 1'b1, 8'h04);
    idle();
    check("R7 late enable asserts irq", {7'd0, irq_n}, 8'h00);
    step('0, 1'b1, 1'b0, 8'h7B);
    check("R4 clear bit2 only", rd_data, 8'h00);
    idle();
    check("R6 irq released", {7'd0, irq_n}, 8'h01);
    step(7'h20, 1'b0, 1'b0, 8'h00);
    idle();
    check("R7 other source masked", {7'd0, irq_n}, 8'h01);
    step('0, 1'b1, 1'b0, 8'h00);
    step('0, 1'b1, 1'b1, 8'h80);
    step(7'h04, 1'b0, 1'b0, 8'h00);
    idle();
    check("R8 bit7 enable write ignored", {7'd0, irq_n}, 8'h01);
    step('0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_irq_latency();
    step('0, 1'b1, 1'b1, 8'h7F);
    step(7'h01, 1'b0, 1'b0, 8'h00);
    check("R6 flag set", rd_data, 8'h01);
    check("R6 irq lags one clock", {7'd0, irq_n}, 8'h01);
    idle();
    check("R6 irq low", {7'd0, irq_n}, 8'h00);
    step('0, 1'b1, 1'b0, 8'h00);
    check("R6 irq still low on clear edge", {7'd0, irq_n}, 8'h00);
    idle();
    check("R6 irq high after clear", {7'd0, irq_n}, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_set_each();
    t_sticky();
    t_clear_partial();
    t_collide();
    t_irq_mask();
    t_irq_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule